// File: doc/BRIEF.md
# Transfer Activation and Completion Sequencer

This block sits in front of a transfer engine that works from descriptors kept in on-chip RAM: two mode words, a source address, a destination address and two count words. It watches several hardware request lines and one software trigger. When an activation is admitted, it looks up that vector's descriptor start address in a vector table and hands the address to the engine. When the engine reports back, the block decides whether to raise a CPU interrupt and which enable or trigger bit to clear or keep.

Each hardware source has a bit in an enable register. A source is admitted only when that bit, the source's own interrupt enable and its request are all high. Software activation is one register write that loads a trigger bit and a vector number, and both can be read back. Software should issue a new one only while the trigger bit reads 0. Only one activation is in flight at a time. The engine's completion report carries two flags: an interrupt-select flag and a count-exhausted flag. Together these decide what happens when the activation ends.

Top module: `xfer_activator`

## Requirements
- R1: After reset, `en_q`, `sw_trig_q`, `sw_vec_q`, `vt_req`, `eng_start`, `done_ready` and `cpu_irq` are all 0.
- R2: Hardware source k is admitted only when `en_q[k]`, `irq_ie[k]` and `irq_req[k]` are all 1. If any of the three is 0, no vector-table request is made for that source.
- R3: While several activations are pending, the lowest-numbered admitted hardware source is served first. Software activation is served only when no hardware source is admitted. A new activation starts only after the previous one has completed.
- R4: Hardware source k uses vector number k, and software activation uses `sw_vec_q`. `vt_req` stays high until `vt_ack`, with `vt_addr` = `vec_base` + 2 × vector.
- R5: In the cycle after a `vt_req`/`vt_ack` handshake, `eng_start` is high for exactly one cycle and `eng_desc` carries the acknowledged `vt_data`. In the next cycle `done_ready` goes high.
- R6: A hardware-activated completion with `done_int_sel`=1 or `done_cnt_zero`=1 clears that source's `en_q` bit. In the following cycle it gives a one-cycle `cpu_irq` pulse, with `cpu_irq_vec` = vector.
- R7: A hardware-activated completion with both flags at 0 leaves `en_q` unchanged and raises no `cpu_irq`.
- R8: A write with `sw_we`=1 loads `sw_trig_q` from `sw_wdata_trig` and `sw_vec_q` from `sw_wdata_vec`, visible in the next cycle. Writing trig=1 requests one software activation.
- R9: A software-activated completion with both flags at 0 clears `sw_trig_q` and raises no `cpu_irq`.
- R10: A software-activated completion with either flag at 1 keeps `sw_trig_q` at 1 and pulses `cpu_irq` with `cpu_irq_vec` = `sw_vec_q`. It does not start another activation until software writes the trigger again.
- R11: Completion flags take effect only on a cycle with `done_valid` and `done_ready` both high. A `done_valid` at any other time has no effect on `cpu_irq` or `en_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Hardware activation requests (level) |
| irq_ie | input | NSRC | Per-source interrupt enables |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NSRC | Enable register write data |
| en_q | output | NSRC | Enable register readback |
| sw_we | input | 1 | Write strobe for the software trigger register |
| sw_wdata_trig | input | 1 | Trigger bit write data |
| sw_wdata_vec | input | VW | Vector number write data |
| sw_trig_q | output | 1 | Trigger bit readback |
| sw_vec_q | output | VW | Vector number readback |
| vec_base | input | AW | Vector table base address |
| vt_req | output | 1 | Vector table read request |
| vt_addr | output | AW | Vector table read address |
| vt_ack | input | 1 | Vector table read acknowledge |
| vt_data | input | AW | Descriptor start address read from the table |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_desc | output | AW | Descriptor start address for the engine |
| done_ready | output | 1 | Block is waiting for the completion report |
| done_valid | input | 1 | Engine completion report valid |
| done_int_sel | input | 1 | Interrupt-select flag of the finished descriptor |
| done_cnt_zero | input | 1 | Transfer count exhausted |
| cpu_irq | output | 1 | One-cycle CPU interrupt pulse |
| cpu_irq_vec | output | VW | Vector of the completed activation |

## Verification
An admitted request shows as `vt_req` one cycle after it is seen. `eng_start` follows one cycle after the table acknowledge, and `done_ready` one cycle after that. Once the report is accepted, `cpu_irq` and the updated `en_q` or `sw_trig_q` appear in the next cycle. The bench drives inputs and samples outputs on the falling edge, and steps exactly those counts of falling edges between a stimulus and its check. Absence checks for gated sources, stray reports and re-activation watch for several cycles, which is longer than any of these latencies.

// File: rtl/xfer_activator.sv
module xfer_activator #(
  parameter int NSRC = 4,
  parameter int VW   = 8,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_ie,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] en_q,
  input  logic            sw_we,
  input  logic            sw_wdata_trig,
  input  logic [VW-1:0]   sw_wdata_vec,
  output logic            sw_trig_q,
  output logic [VW-1:0]   sw_vec_q,
  input  logic [AW-1:0]   vec_base,
  output logic            vt_req,
  output logic [AW-1:0]   vt_addr,
  input  logic            vt_ack,
  input  logic [AW-1:0]   vt_data,
  output logic            eng_start,
  output logic [AW-1:0]   eng_desc,
  output logic            done_ready,
  input  logic            done_valid,
  input  logic            done_int_sel,
  input  logic            done_cnt_zero,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_irq_vec
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_VREQ, S_START, S_WAIT} st_t;

  st_t             state;
  logic [NSRC-1:0] hw_pend;
  logic [SW-1:0]   pick;
  logic [SW-1:0]   cur_src;
  logic [VW-1:0]   cur_vec;
  logic            cur_sw;
  logic            sw_armed;
  logic            done_hs;
  logic            raise;

  assign hw_pend    = en_q & irq_ie & irq_req;
  assign vt_req     = (state == S_VREQ);
  assign vt_addr    = vec_base + AW'({cur_vec, 1'b0});
  assign eng_start  = (state == S_START);
  assign done_ready = (state == S_WAIT);
  assign done_hs    = done_ready & done_valid;
  assign raise      = done_int_sel | done_cnt_zero;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hw_pend[i]) pick = SW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      en_q        <= '0;
      sw_trig_q   <= 1'b0;
      sw_vec_q    <= '0;
      sw_armed    <= 1'b0;
      cur_src     <= '0;
      cur_vec     <= '0;
      cur_sw      <= 1'b0;
      eng_desc    <= '0;
      cpu_irq     <= 1'b0;
      cpu_irq_vec <= '0;
    end else begin
      cpu_irq <= 1'b0;
      case (state)
        S_IDLE:
          if (|hw_pend) begin
            cur_sw  <= 1'b0;
            cur_src <= pick;
            cur_vec <= VW'(pick);
            state   <= S_VREQ;
          end else if (sw_armed) begin
            cur_sw   <= 1'b1;
            cur_vec  <= sw_vec_q;
            sw_armed <= 1'b0;
            state    <= S_VREQ;
          end
        S_VREQ:
          if (vt_ack) begin
            eng_desc <= vt_data;
            state    <= S_START;
          end
        S_START: state <= S_WAIT;
        default:
          if (done_valid) begin
            cpu_irq     <= raise;
            cpu_irq_vec <= cur_vec;
            state       <= S_IDLE;
          end
      endcase

      if (en_we) en_q <= en_wdata;
      if (sw_we) begin
        sw_trig_q <= sw_wdata_trig;
        sw_vec_q  <= sw_wdata_vec;
        sw_armed  <= sw_wdata_trig;
      end

      if (done_hs && !cur_sw && raise) en_q[cur_src] <= 1'b0;
      if (done_hs && cur_sw && !raise) sw_trig_q <= 1'b0;
    end
  end

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VREQ && $past(state) == S_IDLE && !cur_sw)
      |-> ((($past(hw_pend) >> cur_src) & NSRC'(1)) != '0));

  p_prio_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VREQ && $past(state) == S_IDLE && !cur_sw)
      |-> (($past(hw_pend) & ((NSRC'(1) << cur_src) - NSRC'(1))) == '0));

  p_prio_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VREQ && $past(state) == S_IDLE && cur_sw)
      |-> ($past(hw_pend) == '0));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(vt_req && vt_ack));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_hw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !cur_sw) |-> !en_q[cur_src]);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  p_sw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cur_sw && !$past(sw_we)) |-> sw_trig_q);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(done_ready && done_valid));
endmodule

// File: tb/xfer_activator_bench.sv
module xfer_activator_bench;
  localparam int NSRC = 4;
  localparam int VW   = 8;
  localparam int AW   = 16;
  localparam logic [AW-1:0] BASE = 16'h4000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic [NSRC-1:0] irq_ie = '0;
  logic            en_we = 1'b0;
  logic [NSRC-1:0] en_wdata = '0;
  logic [NSRC-1:0] en_q;
  logic            sw_we = 1'b0;
  logic            sw_wdata_trig = 1'b0;
  logic [VW-1:0]   sw_wdata_vec = '0;
  logic            sw_trig_q;
  logic [VW-1:0]   sw_vec_q;
  logic            vt_req;
  logic [AW-1:0]   vt_addr;
  logic            vt_ack = 1'b0;
  logic [AW-1:0]   vt_data = '0;
  logic            eng_start;
  logic [AW-1:0]   eng_desc;
  logic            done_ready;
  logic            done_valid = 1'b0;
  logic            done_int_sel = 1'b0;
  logic            done_cnt_zero = 1'b0;
  logic            cpu_irq;
  logic [VW-1:0]   cpu_irq_vec;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xfer_activator #(.NSRC(NSRC), .VW(VW), .AW(AW)) u_xfer_activator (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ie(irq_ie),
    .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
    .sw_we(sw_we), .sw_wdata_trig(sw_wdata_trig), .sw_wdata_vec(sw_wdata_vec),
    .sw_trig_q(sw_trig_q), .sw_vec_q(sw_vec_q), .vec_base(BASE),
    .vt_req(vt_req), .vt_addr(vt_addr), .vt_ack(vt_ack), .vt_data(vt_data),
    .eng_start(eng_start), .eng_desc(eng_desc), .done_ready(done_ready),
    .done_valid(done_valid), .done_int_sel(done_int_sel), .done_cnt_zero(done_cnt_zero),
    .cpu_irq(cpu_irq), .cpu_irq_vec(cpu_irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [NSRC-1:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic wr_sw(input logic t, input logic [VW-1:0] v);
    sw_we = 1'b1; sw_wdata_trig = t; sw_wdata_vec = v;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic wait_vreq(output bit seen);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (vt_req) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit any = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vt_req || cpu_irq) any = 1;
    end
    chk(!any, tag, int'(any), 0);
  endtask

  task automatic serve(input int vec, input bit isel, input bit cz, input string tag);
    logic [AW-1:0] d;
    bit raise;
    raise = isel | cz;
    d = AW'(16'h1000 + vec * 16);
    chk(vt_addr == AW'(BASE + 2 * vec), {tag, " R4 vt_addr"}, int'(vt_addr), int'(BASE) + 2 * vec);
    vt_ack = 1'b1; vt_data = d;
    @(negedge clk);
    vt_ack = 1'b0;
    chk(eng_start == 1'b1 && eng_desc == d, {tag, " R5 start/desc"}, int'(eng_desc), int'(d));
    @(negedge clk);
    chk(eng_start == 1'b0 && done_ready == 1'b1, {tag, " R5 pulse/ready"},
        int'({eng_start, done_ready}), 1);
    done_valid = 1'b1; done_int_sel = isel; done_cnt_zero = cz;
    @(negedge clk);
    done_valid = 1'b0; done_int_sel = 1'b0; done_cnt_zero = 1'b0;
    chk(cpu_irq == raise, {tag, " R6/R7 cpu_irq"}, int'(cpu_irq), int'(raise));
    if (raise)
      chk(cpu_irq_vec == VW'(vec), {tag, " R6 cpu_irq_vec"}, int'(cpu_irq_vec), vec);
    @(negedge clk);
    chk(cpu_irq == 1'b0, {tag, " R6 pulse width"}, int'(cpu_irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [VW-1:0] svec [4];
    svec[0] = 8'h03; svec[1] = 8'h55; svec[2] = 8'hFF; svec[3] = 8'h80;

    repeat (3) @(negedge clk);
    chk(en_q == '0 && sw_trig_q == 0 && sw_vec_q == '0, "R1 registers", int'(en_q), 0);
    chk(vt_req == 0 && eng_start == 0 && done_ready == 0 && cpu_irq == 0, "R1 outputs",
        int'({vt_req, eng_start, done_ready, cpu_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6, R7: every source, every flag combination
    irq_ie = '1;
    for (int k = 0; k < NSRC; k++) begin
      for (int m = 0; m < 4; m++) begin
        wr_en('1);
        irq_req = NSRC'(1) << k;
        wait_vreq(seen);
        chk(seen, "R2 admitted source", int'(seen), 1);
        irq_req = '0;
        serve(k, m[1], m[0], "hw");
        chk(en_q == ((m != 0) ? ~(NSRC'(1) << k) : '1), "R6/R7 en_q after completion",
            int'(en_q), (m != 0) ? int'(~(NSRC'(1) << k)) : int'(4'hF));
      end
    end

    // R2: gating by each of the two enables
    for (int k = 0; k < NSRC; k++) begin
      wr_en('1);
      irq_ie = ~(NSRC'(1) << k);
      irq_req = NSRC'(1) << k;
      quiet(6, "R2 source ie low");
      irq_req = '0;
      irq_ie = '1;
      wr_en(~(NSRC'(1) << k));
      irq_req = NSRC'(1) << k;
      quiet(6, "R2 source enable low");
      irq_req = '0;
    end

    // R11: stray completion report while idle
    wr_en('1);
    done_valid = 1'b1; done_int_sel = 1'b1; done_cnt_zero = 1'b1;
    quiet(4, "R11 stray done_valid");
    done_valid = 1'b0; done_int_sel = 1'b0; done_cnt_zero = 1'b0;
    @(negedge clk);
    chk(en_q == '1, "R11 en_q unchanged", int'(en_q), 15);

    // R3: priority among hardware and software
    wr_sw(1'b1, 8'h2A);
    irq_req = 4'b1010;
    wait_vreq(seen);
    chk(seen && vt_addr == BASE + 2, "R3 first winner is source 1", int'(vt_addr), int'(BASE) + 2);
    irq_req = 4'b1000;
    serve(1, 0, 0, "R3 s1");
    wait_vreq(seen);
    chk(seen && vt_addr == BASE + 6, "R3 second winner is source 3", int'(vt_addr), int'(BASE) + 6);
    irq_req = '0;
    serve(3, 0, 0, "R3 s3");
    wait_vreq(seen);
    chk(seen && vt_addr == BASE + 16'h54, "R3 software served last", int'(vt_addr), int'(BASE) + 'h54);
    serve(8'h2A, 0, 0, "R3 sw");
    chk(sw_trig_q == 1'b0, "R9 trigger cleared", int'(sw_trig_q), 0);

    // R8, R9, R10: software activation sweep
    wr_en('0);
    for (int v = 0; v < 4; v++) begin
      for (int m = 0; m < 4; m++) begin
        wr_sw(1'b1, svec[v]);
        chk(sw_trig_q == 1'b1 && sw_vec_q == svec[v], "R8 readback", int'(sw_vec_q), int'(svec[v]));
        wait_vreq(seen);
        chk(seen, "R8 software admitted", int'(seen), 1);
        serve(int'(svec[v]), m[1], m[0], "sw");
        chk(sw_trig_q == (m != 0), "R9/R10 trigger after completion", int'(sw_trig_q), int'(m != 0));
        if (m != 0) begin
          quiet(6, "R10 no re-activation");
          wr_sw(1'b0, svec[v]);
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule